// File: doc/BRIEF.md
# External Interrupt Sense and Sleep Control

This peripheral holds the one control register a small microcontroller uses for two jobs: choosing how an external pin raises interrupt 0, and arming the core's sleep instruction. The pin is asynchronous. It passes through a synchronizer and a sample register. A trigger stage then watches it for a low level, a falling edge or a rising edge, as chosen by a two-bit sense code. One code value is reserved, and it never raises a request.

In the edge modes, a detected edge is held in a sticky pending flag until the CPU acknowledges it. In level mode the request follows the sampled pin directly. A request reaches the CPU only while both the global interrupt enable and the source mask are set. When the CPU strobes its sleep instruction, the block issues a one-cycle sleep request, but only if the sleep-enable bit is set. With that request it reports the chosen mode, which it captures at the strobe.

Top module: `extint_sleep_ctrl`

## Requirements
- R1: The control register sits at address `CTRL_ADDR` (default 0x35). It resets to 0x00. Bit 5 is sleep enable, bit 4 is sleep mode and bits 1:0 are the sense code. A write of 0xFF reads back as 0x33.
- R2: Bits 7, 6, 3 and 2 always read as zero, and writing them changes nothing. A read at any other address returns 0x00.
- R3: A sleep strobe raises `sleep_req` for exactly the following cycle, but only when sleep enable is 1. With sleep enable at 0 the strobe has no effect.
- R4: `sleep_mode` takes the value of the mode bit as it stood in the strobe cycle (0 = idle, 1 = power-down). It holds that value until the next accepted strobe. A write in the same cycle as the strobe is not seen by that strobe.
- R5: Sense code 01 is reserved and never raises `irq`, whatever the pin does.
- R6: With sense code 00, `irq` is high while the sampled pin is low. It follows the pin three cycles after a change, with no storage.
- R7: Sense code 10 latches a falling edge and sense code 11 latches a rising edge. `irq` rises four cycles after the pin change.
- R8: A latched edge stays pending until `ack` is pulsed. If `ack` and a newly detected edge fall in the same cycle, the flag stays set.
- R9: A write that changes the sense code clears the pending flag. A write that leaves the code unchanged keeps it.
- R10: `irq` is high only while `gie` and `int_mask` are both 1. A pending edge survives while it is masked.
- R11: A pin pulse held across a single clock period is still latched in the edge modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, zero when the address does not match |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| gie | input | 1 | Global interrupt enable |
| int_mask | input | 1 | Mask bit for this interrupt source |
| ack | input | 1 | CPU acknowledge, clears a pending edge |
| sleep_strobe | input | 1 | The sleep instruction executes |
| irq | output | 1 | Interrupt request to the CPU |
| sleep_req | output | 1 | One-cycle sleep-entry request |
| sleep_mode | output | 1 | Sleep mode captured at the last accepted strobe |

## Verification
Two collisions can fall in the same cycle here.

The first is an acknowledge arriving in the same clock as a freshly detected edge. The bench raises `ack` exactly in the fourth cycle after a second falling edge. It then expects `irq` to stay high, because the new edge must not be lost.

The second is a control-register write that lands on a sleep strobe. The bench writes mode 1 in the strobe cycle and expects the captured mode to be the older value, 0. A companion case writes a new sense code while an edge is pending and expects the flag to be gone one cycle later.

// File: rtl/extint_pkg.sv
package extint_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_RSVD = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int BIT_SLP_EN   = 5;
   localparam int BIT_SLP_MODE = 4;
   localparam int SENSE_LSB    = 0;
endpackage

// File: rtl/extint_ctrl_reg.sv
module extint_ctrl_reg
   import extint_pkg::*;
#(
   parameter int          ADDR_W    = 6,
   parameter int          DATA_W    = 8,
   parameter logic [31:0] CTRL_ADDR = 32'h35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              slp_en,
   output logic              slp_mode,
   output sense_e            sense,
   output logic              sense_chg
);
   localparam logic [DATA_W-1:0] WMASK =
      DATA_W'((1 << BIT_SLP_EN) | (1 << BIT_SLP_MODE) | (3 << SENSE_LSB));

   if (DATA_W < 6) begin : g_bad_width
      $error("extint_ctrl_reg: DATA_W must be at least 6");
   end
   if (CTRL_ADDR >= (32'd1 << ADDR_W)) begin : g_bad_addr
      $error("extint_ctrl_reg: CTRL_ADDR does not fit ADDR_W");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] wr_val;
   logic              hit;

   assign hit       = (reg_addr == CTRL_ADDR[ADDR_W-1:0]);
   assign wr_val    = reg_wdata & WMASK;
   assign sense_chg = hit & reg_wr &
                      (wr_val[SENSE_LSB +: 2] != ctrl_q[SENSE_LSB +: 2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (hit && reg_wr)
         ctrl_q <= wr_val;
   end

   assign reg_rdata = hit ? ctrl_q : '0;
   assign slp_en    = ctrl_q[BIT_SLP_EN];
   assign slp_mode  = ctrl_q[BIT_SLP_MODE];
   assign sense     = sense_e'(ctrl_q[SENSE_LSB +: 2]);
endmodule

// File: rtl/extint_pin_sync.sv
module extint_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic smp,
   output logic prv
);
   if (STAGES < 1) begin : g_bad_stages
      $error("extint_pin_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= IDLE_LV;
            else        chain[0] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= IDLE_LV;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp <= IDLE_LV;
         prv <= IDLE_LV;
      end else begin
         smp <= chain[STAGES-1];
         prv <= smp;
      end
   end
endmodule

// File: rtl/extint_trigger.sv
module extint_trigger
   import extint_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  sense_e sense,
   input  logic   sense_chg,
   input  logic   smp,
   input  logic   prv,
   input  logic   ack,
   input  logic   gie,
   input  logic   int_mask,
   output logic   pending,
   output logic   irq
);
   logic fall_det, rise_det, edge_hit, raw_req;

   assign fall_det = prv & ~smp;
   assign rise_det = ~prv & smp;
   assign edge_hit = ((sense == SENSE_FALL) & fall_det) |
                     ((sense == SENSE_RISE) & rise_det);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pending <= 1'b0;
      else if (sense_chg) pending <= 1'b0;
      else if (edge_hit)  pending <= 1'b1;
      else if (ack)       pending <= 1'b0;
   end

   always_comb begin
      unique case (sense)
         SENSE_LOW:  raw_req = ~smp;
         SENSE_RSVD: raw_req = 1'b0;
         default:    raw_req = pending;
      endcase
   end

   assign irq = raw_req & gie & int_mask;
endmodule

// File: rtl/extint_sleep.sv
module extint_sleep (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_strobe,
   input  logic slp_en,
   input  logic slp_mode,
   output logic sleep_req,
   output logic sleep_mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_req  <= 1'b0;
         sleep_mode <= 1'b0;
      end else if (sleep_strobe && slp_en) begin
         sleep_req  <= 1'b1;
         sleep_mode <= slp_mode;
      end else begin
         sleep_req  <= 1'b0;
      end
   end
endmodule

// File: rtl/extint_sleep_ctrl.sv
module extint_sleep_ctrl
   import extint_pkg::*;
#(
   parameter int          ADDR_W      = 6,
   parameter int          DATA_W      = 8,
   parameter logic [31:0] CTRL_ADDR   = 32'h35,
   parameter int          SYNC_STAGES = 2,
   parameter logic        PIN_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              pin_in,
   input  logic              gie,
   input  logic              int_mask,
   input  logic              ack,
   input  logic              sleep_strobe,
   output logic              irq,
   output logic              sleep_req,
   output logic              sleep_mode
);
   logic   ctl_se, ctl_sm, sense_chg, pin_smp, pin_prv, edge_pend;
   sense_e ctl_sense;

   extint_ctrl_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slp_en(ctl_se),
      .slp_mode(ctl_sm), .sense(ctl_sense), .sense_chg(sense_chg)
   );

   extint_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .smp(pin_smp), .prv(pin_prv)
   );

   extint_trigger u_trig (
      .clk(clk), .rst_n(rst_n), .sense(ctl_sense), .sense_chg(sense_chg),
      .smp(pin_smp), .prv(pin_prv), .ack(ack), .gie(gie),
      .int_mask(int_mask), .pending(edge_pend), .irq(irq)
   );

   extint_sleep u_slp (
      .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .slp_en(ctl_se),
      .slp_mode(ctl_sm), .sleep_req(sleep_req), .sleep_mode(sleep_mode)
   );
endmodule

// File: rtl/extint_sleep_chk.sv
module extint_sleep_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              sleep_strobe,
   input logic              ctl_se,
   input logic              ctl_sm,
   input logic              sleep_req,
   input logic              sleep_mode,
   input logic [1:0]        ctl_sense,
   input logic              sense_chg,
   input logic              edge_pend,
   input logic              pin_smp,
   input logic              gie,
   input logic              int_mask,
   input logic              irq
);
   AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[7:6] == 2'b00) && (reg_rdata[3:2] == 2'b00)); // R2
   AST_SLEEP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |-> $past(sleep_strobe && ctl_se)); // R3
   AST_SLEEP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_strobe && !ctl_se) |=> !sleep_req); // R3
   AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_strobe && ctl_se) |=> (sleep_mode == $past(ctl_sm))); // R4
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(sleep_strobe && ctl_se) |=> $stable(sleep_mode)); // R4
   AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_sense == 2'b01) |-> !irq); // R5
   AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_sense == 2'b00 && gie && int_mask && !pin_smp) |-> irq); // R6
   AST_CODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sense_chg |=> !edge_pend); // R9
   AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (gie && int_mask)); // R10
endmodule

bind extint_sleep_ctrl extint_sleep_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
   .sleep_strobe(sleep_strobe), .ctl_se(ctl_se), .ctl_sm(ctl_sm),
   .sleep_req(sleep_req), .sleep_mode(sleep_mode), .ctl_sense(ctl_sense),
   .sense_chg(sense_chg), .edge_pend(edge_pend), .pin_smp(pin_smp),
   .gie(gie), .int_mask(int_mask), .irq(irq)
);

// File: tb/tb_extint_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_extint_sleep_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] reg_addr = 6'h35;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       pin_in = 1'b1;
   logic       gie = 1'b0, int_mask = 1'b0, ack = 1'b0, sleep_strobe = 1'b0;
   logic       irq, sleep_req, sleep_mode;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   extint_sleep_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .gie(gie), .int_mask(int_mask), .ack(ack), .sleep_strobe(sleep_strobe),
      .irq(irq), .sleep_req(sleep_req), .sleep_mode(sleep_mode)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step(1);
      reg_wr = 1'b0; reg_addr = 6'h35;
   endtask

   task automatic pulse_ack();
      ack = 1'b1; step(1); ack = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 reset rdata", reg_rdata, 8'h00);
      chk("R1 reset irq", {7'd0, irq}, 8'h00);
      chk("R3 reset sleep_req", {7'd0, sleep_req}, 8'h00);
      // R1 / R2 register layout
      wr(6'h35, 8'hFF);
      chk("R1 readback FF", reg_rdata, 8'h33);
      wr(6'h35, 8'hCC);
      chk("R2 reserved bits ignored", reg_rdata, 8'h00);
      wr(6'h35, 8'h12);
      reg_addr = 6'h34; step(1);
      chk("R2 other address reads zero", reg_rdata, 8'h00);
      reg_addr = 6'h35; step(1);
      chk("R1 readback 12", reg_rdata, 8'h12);
      wr(6'h35, 8'h00);

      // R5 R6 R7 R10 sweep over sense code and enables
      for (int c = 0; c < 4; c++) begin
         for (int gm = 0; gm < 4; gm++) begin
            logic en;
            en = (gm == 3);
            gie = gm[0]; int_mask = gm[1];
            pin_in = 1'b1;
            wr(6'h35, 8'(c));
            pulse_ack();
            step(5);
            chk("R10 idle no request", {7'd0, irq}, 8'h00);
            pin_in = 1'b0;
            step(3);
            chk(c == 1 ? "R5 low 3cyc" : "R6 level 3cyc", {7'd0, irq},
                {7'd0, en & (c == 0)});
            step(1);
            chk(c == 2 ? "R7 fall 4cyc" : "R10 low 4cyc", {7'd0, irq},
                {7'd0, en & (c == 0 || c == 2)});
            pin_in = 1'b1;
            step(4);
            chk(c == 3 ? "R7 rise 4cyc" : "R8 sticky after high", {7'd0, irq},
                {7'd0, en & (c == 2 || c == 3)});
            pulse_ack();
            step(1);
            chk("R8 ack clears", {7'd0, irq}, 8'h00);
         end
      end

      // R8 ack in the same cycle as a new edge
      gie = 1'b1; int_mask = 1'b1;
      wr(6'h35, 8'h02);
      pin_in = 1'b0; step(5);
      chk("R8 first edge", {7'd0, irq}, 8'h01);
      pin_in = 1'b1; step(5);
      pin_in = 1'b0; step(3);
      ack = 1'b1; step(1); ack = 1'b0;
      chk("R8 ack with new edge keeps", {7'd0, irq}, 8'h01);
      step(1);
      chk("R8 still pending", {7'd0, irq}, 8'h01);

      // R9 same code keeps, new code clears
      wr(6'h35, 8'h02);
      chk("R9 same code keeps", {7'd0, irq}, 8'h01);
      wr(6'h35, 8'h03);
      chk("R9 code change clears", {7'd0, irq}, 8'h00);
      pin_in = 1'b1; step(5);
      pulse_ack();

      // R10 pending survives mask
      wr(6'h35, 8'h02);
      gie = 1'b0;
      pin_in = 1'b0; step(6);
      chk("R10 masked", {7'd0, irq}, 8'h00);
      gie = 1'b1; #1;
      chk("R10 unmasked pending", {7'd0, irq}, 8'h01);
      pin_in = 1'b1; step(5);
      pulse_ack(); step(1);

      // R11 one-cycle pulse
      pin_in = 1'b0; step(1); pin_in = 1'b1;
      step(5);
      chk("R11 narrow pulse latched", {7'd0, irq}, 8'h01);
      pulse_ack(); step(1);
      gie = 1'b0; int_mask = 1'b0;

      // R3 / R4 sleep
      wr(6'h35, 8'h10);
      sleep_strobe = 1'b1; step(1); sleep_strobe = 1'b0;
      chk("R3 no sleep without enable", {7'd0, sleep_req}, 8'h00);
      wr(6'h35, 8'h30);
      sleep_strobe = 1'b1; step(1); sleep_strobe = 1'b0;
      chk("R3 sleep pulse", {7'd0, sleep_req}, 8'h01);
      chk("R4 power-down captured", {7'd0, sleep_mode}, 8'h01);
      step(1);
      chk("R3 pulse one cycle", {7'd0, sleep_req}, 8'h00);
      wr(6'h35, 8'h20);
      chk("R4 mode held", {7'd0, sleep_mode}, 8'h01);
      sleep_strobe = 1'b1; step(1); sleep_strobe = 1'b0;
      chk("R4 idle captured", {7'd0, sleep_mode}, 8'h00);
      // write and strobe in the same cycle
      reg_wdata = 8'h30; reg_wr = 1'b1; sleep_strobe = 1'b1;
      step(1);
      reg_wr = 1'b0; sleep_strobe = 1'b0;
      chk("R3 strobe with write", {7'd0, sleep_req}, 8'h01);
      chk("R4 old mode used", {7'd0, sleep_mode}, 8'h00);

      done = 1'b1;
      finish_run();
   end
endmodule